// File: doc/BRIEF.md
# Shared Multi-Channel Word Boundary Aligner

This block restores word framing on eight deserialized lanes, each delivering a 6-bit word every clock. The framing of each lane is unknown after link bring-up. Every lane has its own boundary shifter. The shifter builds a 12-bit window from the two most recent raw words and takes six bits from it at a rotation offset. A single search state machine is time-shared across the lanes. A lane-select value routes the chosen lane's aligned word to one comparator, and routes the slip command back to that lane alone.

Software or a bring-up sequencer has the transmitter send the training word `111000` on every lane and holds `train_en` high. It then pulses `start`. The search works through the lanes in order from 0 to 7. For each lane it compares the aligned word with the training word and bumps the lane's offset by one on a mismatch. After each bump it waits two settle cycles before comparing again. A lane that never matches within six slips is flagged as failed and skipped. When the last lane has been handled, `all_done` rises and stays high. The offsets are kept, so a later `start` on the same data finds every lane already framed.

The search states are IDLE, SETTLE, COMPARE, SLIP, NEXT and DONE. The transitions are:
- IDLE→SETTLE and DONE→SETTLE on an accepted start.
- SETTLE→COMPARE once the settle count is used up.
- COMPARE→NEXT on a match or when the slip budget is exhausted.
- COMPARE→SLIP on a mismatch with budget left.
- SLIP→SETTLE after the slip.
- NEXT→SETTLE for the following lane, or NEXT→DONE after the last lane.

Every state other than IDLE and DONE freezes while `train_en` is low.

Top module: `word_align_hub`

## Requirements
- R1: While reset is asserted, and right after it, `aligned_words`, `lane_locked`, `lane_err` and `all_done` are all zero. Every lane offset starts at 0.
- R2: For each lane n, the aligned word is bits [off+5:off] of {current raw word, previous raw word}, where the previous word sits in the low six bits. For constant raw data R this is R rotated right by off. The aligned word is valid after three clock edges of constant input. With offset 0, aligned equals raw.
- R3: `start` is accepted only when `train_en` is high and the search is in IDLE or DONE. A start at any other time changes neither the timing nor the flags.
- R4: Lanes are searched one at a time in order 0 to 7. A slip reaches only the selected lane. At every moment, {locked|err} forms a contiguous run of ones from bit 0.
- R5: A lane whose aligned word equals `111000` is marked locked. After the search, its aligned output reads `111000`.
- R6: Each comparison is preceded by exactly two settle cycles. A lane that needs k slips costs 4k+4 cycles. `all_done` rises on the Nth clock edge after the edge that accepts start, where N is the sum of these costs over all lanes.
- R7: A lane that has not matched after six slips gets its `lane_err` bit set and its locked bit left clear. The search moves on. Because six slips wrap the offset, the lane's offset ends where it started. Such a lane costs 28 cycles.
- R8: `all_done` stays high until the next accepted start. An accepted start clears all locked and error flags on the same edge. Offsets are kept across starts.
- R9: While `train_en` is low during a search, offsets, aligned words and flags hold. The search resumes afterwards, so the completion time grows by exactly the number of low cycles.
- R10: No lane is both locked and failed. While `all_done` is high, every lane is either locked or failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_words | input | 48 | Raw deserialized words, lane n at bits [6n+5:6n] |
| start | input | 1 | Begin a search over all lanes |
| train_en | input | 1 | Training data present; low freezes the search |
| aligned_words | output | 48 | Re-framed words, lane n at bits [6n+5:6n] |
| lane_locked | output | 8 | Lane matched the training word |
| lane_err | output | 8 | Lane failed to match within six slips |
| all_done | output | 1 | Search over all lanes finished |

## Verification
The hardest situation to reach is a lane with an exhausted slip budget that sits between lanes needing a large number of slips. This is the only case that exposes an off-by-one in the budget, the offset wrap and the per-lane cycle cost at the same time. The stimulus drives each lane with a constant rotation of the training word, picked to need a chosen number of slips from 0 to 5. One lane gets an alternating pattern that no rotation can turn into the training word. The exact edge on which the search finishes is then predicted from the per-lane costs. The bench repeats the run with retained offsets, and runs it again with a mid-search training pause and a stray start.

// File: rtl/wal_pkg.sv
package wal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_COMPARE,
        ST_SLIP,
        ST_NEXT,
        ST_DONE
    } wal_state_t;

endpackage

// File: rtl/wal_lane.sv
module wal_lane #(
    parameter int WORD_W = 6,
    localparam int OFF_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] raw,
    input  logic              slip,
    output logic [WORD_W-1:0] aligned,
    output logic [OFF_W-1:0]  offset
);

    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(WORD_W - 1);

    logic [WORD_W-1:0]   cur_q;
    logic [WORD_W-1:0]   prev_q;
    logic [OFF_W-1:0]    off_q;
    logic [WORD_W-1:0]   aligned_q;
    logic [2*WORD_W-1:0] window;

    assign window = {cur_q, prev_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= '0;
            prev_q    <= '0;
            aligned_q <= '0;
        end else begin
            cur_q     <= raw;
            prev_q    <= cur_q;
            aligned_q <= WORD_W'(window >> off_q);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (slip) begin
            off_q <= (off_q == OFF_LAST) ? '0 : off_q + 1'b1;
        end
    end

    assign aligned = aligned_q;
    assign offset  = off_q;

endmodule

// File: rtl/wal_select.sv
module wal_select #(
    parameter int NUM_LANES = 8,
    parameter int WORD_W    = 6,
    localparam int LANE_W   = $clog2(NUM_LANES)
) (
    input  logic [NUM_LANES*WORD_W-1:0] aligned_bus,
    input  logic [LANE_W-1:0]           sel,
    input  logic                        slip_req,
    output logic [WORD_W-1:0]           sel_word,
    output logic [NUM_LANES-1:0]        slip_vec
);

    assign sel_word = aligned_bus[sel*WORD_W +: WORD_W];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_demux
        assign slip_vec[g] = slip_req && (sel == LANE_W'(g));
    end

endmodule

// File: rtl/wal_sequencer.sv
module wal_sequencer
    import wal_pkg::*;
#(
    parameter int NUM_LANES  = 8,
    parameter int WORD_W     = 6,
    parameter logic [WORD_W-1:0] TRAIN_WORD = 6'b111000,
    parameter int SETTLE_CYC = 2,
    parameter int MAX_SLIPS  = WORD_W,
    localparam int LANE_W    = $clog2(NUM_LANES),
    localparam int SCNT_W    = $clog2(MAX_SLIPS + 1),
    localparam int WAIT_W    = $clog2(SETTLE_CYC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 train_en,
    input  logic [WORD_W-1:0]    sel_word,
    output logic [LANE_W-1:0]    sel,
    output logic                 slip_req,
    output logic [NUM_LANES-1:0] locked,
    output logic [NUM_LANES-1:0] failed,
    output logic                 done
);

    localparam logic [LANE_W-1:0] LANE_LAST   = LANE_W'(NUM_LANES - 1);
    localparam logic [SCNT_W-1:0] SLIP_LIMIT  = SCNT_W'(MAX_SLIPS);
    localparam logic [WAIT_W-1:0] WAIT_RELOAD = WAIT_W'(SETTLE_CYC - 1);

    wal_state_t             st_q, st_n;
    logic [LANE_W-1:0]      lane_q, lane_n;
    logic [SCNT_W-1:0]      scnt_q, scnt_n;
    logic [WAIT_W-1:0]      wcnt_q, wcnt_n;
    logic [NUM_LANES-1:0]   lk_q, lk_n;
    logic [NUM_LANES-1:0]   er_q, er_n;
    logic                   match;

    assign match = (sel_word == TRAIN_WORD);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            lane_q <= '0;
            scnt_q <= '0;
            wcnt_q <= '0;
            lk_q   <= '0;
            er_q   <= '0;
        end else begin
            st_q   <= st_n;
            lane_q <= lane_n;
            scnt_q <= scnt_n;
            wcnt_q <= wcnt_n;
            lk_q   <= lk_n;
            er_q   <= er_n;
        end
    end

    // transitions
    always_comb begin
        st_n   = st_q;
        lane_n = lane_q;
        scnt_n = scnt_q;
        wcnt_n = wcnt_q;
        lk_n   = lk_q;
        er_n   = er_q;
        unique case (st_q)
            ST_IDLE, ST_DONE: begin
                if (start && train_en) begin
                    st_n   = ST_SETTLE;
                    lane_n = '0;
                    scnt_n = '0;
                    wcnt_n = WAIT_RELOAD;
                    lk_n   = '0;
                    er_n   = '0;
                end
            end
            ST_SETTLE: begin
                if (train_en) begin
                    if (wcnt_q == '0) st_n = ST_COMPARE;
                    else              wcnt_n = wcnt_q - 1'b1;
                end
            end
            ST_COMPARE: begin
                if (train_en) begin
                    if (match) begin
                        lk_n[lane_q] = 1'b1;
                        st_n         = ST_NEXT;
                    end else if (scnt_q == SLIP_LIMIT) begin
                        er_n[lane_q] = 1'b1;
                        st_n         = ST_NEXT;
                    end else begin
                        st_n = ST_SLIP;
                    end
                end
            end
            ST_SLIP: begin
                if (train_en) begin
                    scnt_n = scnt_q + 1'b1;
                    wcnt_n = WAIT_RELOAD;
                    st_n   = ST_SETTLE;
                end
            end
            ST_NEXT: begin
                if (train_en) begin
                    if (lane_q == LANE_LAST) begin
                        st_n = ST_DONE;
                    end else begin
                        lane_n = lane_q + 1'b1;
                        scnt_n = '0;
                        wcnt_n = WAIT_RELOAD;
                        st_n   = ST_SETTLE;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sel      = lane_q;
        slip_req = (st_q == ST_SLIP) && train_en;
        locked   = lk_q;
        failed   = er_q;
        done     = (st_q == ST_DONE);
    end

endmodule

// File: rtl/word_align_hub.sv
module word_align_hub #(
    parameter int NUM_LANES  = 8,
    parameter int WORD_W     = 6,
    parameter logic [WORD_W-1:0] TRAIN_WORD = 6'b111000,
    parameter int SETTLE_CYC = 2,
    parameter int MAX_SLIPS  = WORD_W,
    localparam int BUS_W     = NUM_LANES * WORD_W,
    localparam int LANE_W    = $clog2(NUM_LANES),
    localparam int OFF_W     = $clog2(WORD_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BUS_W-1:0]     raw_words,
    input  logic                 start,
    input  logic                 train_en,
    output logic [BUS_W-1:0]     aligned_words,
    output logic [NUM_LANES-1:0] lane_locked,
    output logic [NUM_LANES-1:0] lane_err,
    output logic                 all_done
);

    logic [BUS_W-1:0]           aligned_bus;
    logic [NUM_LANES*OFF_W-1:0] off_all;
    logic [NUM_LANES-1:0]       slip_vec;
    logic [WORD_W-1:0]          sel_word;
    logic [LANE_W-1:0]          sel;
    logic                       slip_req;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        wal_lane #(.WORD_W(WORD_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw     (raw_words[g*WORD_W +: WORD_W]),
            .slip    (slip_vec[g]),
            .aligned (aligned_bus[g*WORD_W +: WORD_W]),
            .offset  (off_all[g*OFF_W +: OFF_W])
        );
    end

    wal_select #(.NUM_LANES(NUM_LANES), .WORD_W(WORD_W)) u_select (
        .aligned_bus (aligned_bus),
        .sel         (sel),
        .slip_req    (slip_req),
        .sel_word    (sel_word),
        .slip_vec    (slip_vec)
    );

    wal_sequencer #(
        .NUM_LANES  (NUM_LANES),
        .WORD_W     (WORD_W),
        .TRAIN_WORD (TRAIN_WORD),
        .SETTLE_CYC (SETTLE_CYC),
        .MAX_SLIPS  (MAX_SLIPS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .train_en (train_en),
        .sel_word (sel_word),
        .sel      (sel),
        .slip_req (slip_req),
        .locked   (lane_locked),
        .failed   (lane_err),
        .done     (all_done)
    );

    assign aligned_words = aligned_bus;

endmodule

// File: rtl/wal_checker.sv
module wal_checker #(
    parameter int NUM_LANES = 8,
    parameter int WORD_W    = 6,
    localparam int OFF_W    = $clog2(WORD_W)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic                       train_en,
    input logic                       all_done,
    input logic [NUM_LANES-1:0]       lane_locked,
    input logic [NUM_LANES-1:0]       lane_err,
    input logic [NUM_LANES-1:0]       slip_vec,
    input logic [NUM_LANES*OFF_W-1:0] off_all
);

    logic [NUM_LANES-1:0] handled;
    assign handled = lane_locked | lane_err;

    // R4
    slip_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slip_vec));

    // R4
    handled_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (handled & (handled + 1'b1)) == '0);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_off
        // R2
        offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            off_all[g*OFF_W +: OFF_W] < OFF_W'(WORD_W));
    end

    // R9
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !train_en |=> $stable(off_all));

    // R10
    lock_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_locked & lane_err) == '0);

    // R10
    done_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |-> (&handled));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (all_done && !(start && train_en)) |=> all_done);

endmodule

bind word_align_hub wal_checker #(
    .NUM_LANES (NUM_LANES),
    .WORD_W    (WORD_W)
) u_wal_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .train_en    (train_en),
    .all_done    (all_done),
    .lane_locked (lane_locked),
    .lane_err    (lane_err),
    .slip_vec    (slip_vec),
    .off_all     (off_all)
);

// File: tb/word_align_hub_test.sv
`timescale 1ns/1ps
module word_align_hub_test;

    localparam int NL = 8;
    localparam int W  = 6;
    localparam logic [W-1:0] TW = 6'b111000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL*W-1:0] raw_words = '0;
    logic          start = 1'b0;
    logic          train_en = 1'b0;
    logic [NL*W-1:0] aligned_words;
    logic [NL-1:0] lane_locked;
    logic [NL-1:0] lane_err;
    logic          all_done;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    word_align_hub uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .raw_words     (raw_words),
        .start         (start),
        .train_en      (train_en),
        .aligned_words (aligned_words),
        .lane_locked   (lane_locked),
        .lane_err      (lane_err),
        .all_done      (all_done)
    );

    function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int k);
        logic [W-1:0] r = v;
        for (int i = 0; i < k; i++) r = {r[W-2:0], r[W-1]};
        return r;
    endfunction

    function automatic logic [W-1:0] rotr(input logic [W-1:0] v, input int k);
        logic [W-1:0] r = v;
        for (int i = 0; i < k; i++) r = {r[0], r[W-1:1]};
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Pulse start, then count edges until all_done; optional pause and stray start.
    task automatic run_search(input int pause_at, input int pause_len,
                              input int stray_at, output int edges);
        logic [NL*W-1:0] snap_al;
        logic [NL-1:0]   snap_lk;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        // R8: flags cleared on the accepting edge
        check("R8", "locked cleared on start", 64'(lane_locked), 64'd0);
        check("R8", "err cleared on start", 64'(lane_err), 64'd0);
        check("R8", "done low after start", 64'(all_done), 64'd0);
        edges = 0;
        while (edges < 2000) begin
            @(posedge clk);
            #1;
            edges++;
            if (edges == stray_at) begin
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (edges == pause_at) begin
                train_en = 1'b0;
                snap_lk  = lane_locked;
            end
            if (pause_len > 0 && edges == pause_at + 2) snap_al = aligned_words;
            if (pause_len > 0 && edges > pause_at + 2 && edges < pause_at + pause_len) begin
                // R9: frozen while training paused
                check("R9", "aligned held in pause", 64'(aligned_words), 64'(snap_al));
            end
            if (pause_len > 0 && edges > pause_at && edges < pause_at + pause_len) begin
                check("R9", "locked held in pause", 64'(lane_locked), 64'(snap_lk));
            end
            if (pause_len > 0 && edges == pause_at + pause_len) train_en = 1'b1;
            if (all_done) break;
        end
        start = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "aligned in reset", 64'(aligned_words), 64'd0);
        check("R1", "locked in reset", 64'(lane_locked), 64'd0);
        check("R1", "err in reset", 64'(lane_err), 64'd0);
        check("R1", "done in reset", 64'(all_done), 64'd0);
    endtask

    task automatic t_passthrough();
        logic [NL*W-1:0] pat;
        for (int i = 0; i < NL; i++) pat[i*W +: W] = W'(i * 7 + 3);
        @(negedge clk);
        raw_words = pat;
        repeat (3) @(posedge clk);
        #1;
        // R2: offset 0 after reset gives aligned == raw
        check("R2", "offset0 passthrough", 64'(aligned_words), 64'(pat));
        check("R1", "done idle after reset", 64'(all_done), 64'd0);
    endtask

    task automatic t_full_align();
        int k[NL] = '{0, 1, 2, 3, 4, 5, 6, 2};
        int expn = 0;
        int got;
        logic [NL*W-1:0] exp_al;
        @(negedge clk);
        train_en = 1'b1;
        for (int i = 0; i < NL; i++) begin
            if (k[i] == 6) raw_words[i*W +: W] = 6'b101010;
            else           raw_words[i*W +: W] = rotl(TW, k[i]);
            expn += 4 * k[i] + 4;
            exp_al[i*W +: W] = (k[i] == 6) ? 6'b101010 : TW;
        end
        repeat (3) @(posedge clk);
        run_search(-10, 0, -10, got);
        // R6 / R7: exact completion edge including the failed lane's 28 cycles
        check("R6", "first search length", 64'(got), 64'(expn));
        check("R5", "locked lanes", 64'(lane_locked), 64'hBF);
        check("R7", "failed lane flag", 64'(lane_err), 64'h40);
        check("R5", "aligned words framed", 64'(aligned_words), 64'(exp_al));
        repeat (5) @(posedge clk);
        #1;
        check("R8", "done held", 64'(all_done), 64'd1);
    endtask

    task automatic t_retained();
        int got;
        run_search(-10, 0, -10, got);
        // R8: offsets retained, so locked lanes need no slips (7*4 + 28)
        check("R8", "repeat search length", 64'(got), 64'd56);
        check("R10", "flags after repeat", 64'(lane_locked | lane_err), 64'hFF);
        check("R10", "no lane both", 64'(lane_locked & lane_err), 64'd0);
    endtask

    task automatic t_pause_and_stray();
        int offs[NL] = '{0, 1, 2, 3, 4, 5, 0, 2};
        int expn = 0;
        int got;
        logic [NL*W-1:0] exp_al;
        @(negedge clk);
        for (int i = 0; i < NL; i++) begin
            raw_words[i*W +: W] = TW;
            expn += 4 * ((W - offs[i]) % W) + 4;
            exp_al[i*W +: W] = TW;
        end
        repeat (3) @(posedge clk);
        run_search(20, 15, 5, got);
        // R9 pause adds its length; R3 stray start during busy ignored
        check("R9", "paused search length", 64'(got), 64'(expn + 15));
        check("R3", "busy start ignored", 64'(lane_locked), 64'hFF);
        check("R5", "all lanes framed", 64'(aligned_words), 64'(exp_al));
        // R3: start with training off in DONE is ignored
        @(negedge clk);
        train_en = 1'b0;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R3", "done kept on gated start", 64'(all_done), 64'd1);
        check("R3", "locked kept on gated start", 64'(lane_locked), 64'hFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary_and_end();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_passthrough();
        t_full_align();
        t_retained();
        t_pause_and_stray();
        summary_and_end();
    end

endmodule